// File: doc/BRIEF.md
# Latched Multi-Source Interrupt Controller

This block gathers interrupt requests from a small set of peripheral sources and turns them into one latched interrupt line toward the processor. Each source has a fixed bit position in three 32-bit registers. The mask register selects which sources may record events, and its top bit enables the whole controller. The levels register follows the current line state of every source. The events register records which enabled sources have changed since the last clear. A source reports a change by pulsing its change strobe for one cycle. On the same cycle it presents its new line state.

Software uses a small register port to read the three registers, write the mask, and write a clear register. A clear write can be global: it empties the events register and releases the processor interrupt. A clear write can also be partial: it ANDs the events register with the written value and leaves the interrupt latch as it is. All register data crosses the port in swapped byte order. A change that arrives while the controller is disabled is not processed. Instead it raises an error pulse.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the mask, levels and events registers are zero, the processor interrupt is low, the error pulse is low and the read data is zero.
- R2: Source 0 owns register bit 18, source 1 owns bit 12 and source 2 owns bit 19. Mask bit 31 is the enable (mode) bit.
- R3: On a change strobe while the mode bit is set, the source's bit is ORed into events. Events is then ANDed with the mask value held before that cycle, so a masked source records no event.
- R4: On a change strobe while the mode bit is set, the source's bit in levels becomes 1 if its line state is high and 0 if it is low, whatever the mask holds for that bit.
- R5: The processor interrupt goes high on the clock edge after a source update that leaves events nonzero. It stays high until a global clear, even if events later becomes zero.
- R6: A write to the clear register whose byte-swapped value has bit 31 set (bit 7 of the raw bus word) zeroes events and drops the processor interrupt on the next edge.
- R7: A write to the clear register without that bit ANDs events with the byte-swapped written value and leaves the processor interrupt unchanged.
- R8: The registers sit at these byte offsets: events 0x20, mask 0x24, clear 0x28, levels 0x2C. The read data of a request appears on the cycle after the request. Mask writes and all read data are byte-swapped (bus byte 0 carries register bits 31:24). The clear register and all unused offsets read 0.
- R9: A change strobe while the mode bit is clear leaves events, levels and the interrupt unchanged. It raises the error output for exactly one cycle, on the next edge.
- R10: When a clear write and a source change fall in the same cycle, the clear takes effect first and the source update second. After a global clear, the new change therefore survives in events and sets the interrupt again.
- R11: Changes from several sources in the same cycle are all recorded in events and levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_chg_i | input | NUM_SRC | Per-source change strobe, one cycle |
| src_lvl_i | input | NUM_SRC | Per-source new line state, sampled with the strobe |
| reg_rd_i | input | 1 | Register read request |
| reg_wr_i | input | 1 | Register write request |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Write data in bus byte order |
| reg_rdata_o | output | 32 | Registered read data in bus byte order |
| cpu_irq_o | output | 1 | Latched processor interrupt |
| mode_err_o | output | 1 | One-cycle pulse for a change that arrives while disabled |

## Verification
Two operations can fall in the same cycle: a source update and a clear-register write. The bench drives a global clear and a change strobe on the same clock edge while events and the latch are already set. It then reads events and levels back and checks the interrupt. A correct design shows only the new source bit in events and keeps the interrupt high. A design that applies the two in the wrong order shows an empty events register and a low interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W    = 32;
  localparam int POS_W    = $clog2(REG_W);
  localparam int MODE_BIT = 31;
  localparam int GCLR_BIT = 31;

  function automatic logic [REG_W-1:0] swap32(input logic [REG_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/irqc_src_map.sv
module irqc_src_map
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd19, 5'd12, 5'd18}
) (
  input  logic [NUM_SRC-1:0] chg_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [REG_W-1:0]   chg_vec_o,
  output logic [REG_W-1:0]   hi_vec_o
);
  logic [REG_W-1:0] chg_one [NUM_SRC];
  logic [REG_W-1:0] hi_one  [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [POS_W-1:0] P = SRC_POS[g*POS_W +: POS_W];
    always_comb begin
      chg_one[g]    = '0;
      hi_one[g]     = '0;
      chg_one[g][P] = chg_i[g];
      hi_one[g][P]  = chg_i[g] & lvl_i[g];
    end
  end

  always_comb begin
    chg_vec_o = '0;
    hi_vec_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      chg_vec_o = chg_vec_o | chg_one[i];
      hi_vec_o  = hi_vec_o | hi_one[i];
    end
  end
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_EVT = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_MSK = 8'h24,
  parameter logic [ADDR_W-1:0] OFF_CLR = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_LVL = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  mask_i,
  input  logic [REG_W-1:0]  lvl_i,
  input  logic [REG_W-1:0]  evt_i,
  output logic              mask_wr_o,
  output logic [REG_W-1:0]  mask_val_o,
  output logic              clr_wr_o,
  output logic [REG_W-1:0]  clr_val_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] rd_mux;

  assign mask_wr_o  = wr_i && (addr_i == OFF_MSK);
  assign clr_wr_o   = wr_i && (addr_i == OFF_CLR);
  assign mask_val_o = swap32(wdata_i);
  assign clr_val_o  = swap32(wdata_i);

  always_comb begin
    if (addr_i == OFF_EVT)      rd_mux = evt_i;
    else if (addr_i == OFF_MSK) rd_mux = mask_i;
    else if (addr_i == OFF_LVL) rd_mux = lvl_i;
    else                        rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= swap32(rd_mux);
    else           rdata_o <= '0;
  end

  // R8: unused offsets and the clear register read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i != OFF_EVT && addr_i != OFF_MSK && addr_i != OFF_LVL)
      |=> (rdata_o == '0));
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] chg_vec_i,
  input  logic [REG_W-1:0] hi_vec_i,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] mask_val_i,
  input  logic             clr_wr_i,
  input  logic [REG_W-1:0] clr_val_i,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] lvl_q,
  output logic [REG_W-1:0] evt_q,
  output logic             irq_o,
  output logic             err_o
);
  logic             gclr, mode, act, any_chg, latch_a;
  logic [REG_W-1:0] ev_a, ev_b, lvl_n;

  assign any_chg = |chg_vec_i;
  assign mode    = mask_q[MODE_BIT];
  assign act     = mode && any_chg;
  assign gclr    = clr_wr_i && clr_val_i[GCLR_BIT];

  // clear stage first
  always_comb begin
    if (gclr)          ev_a = '0;
    else if (clr_wr_i) ev_a = evt_q & clr_val_i;
    else               ev_a = evt_q;
    latch_a = gclr ? 1'b0 : irq_o;
  end

  // source stage second
  always_comb begin
    ev_b  = act ? ((ev_a | chg_vec_i) & mask_q) : ev_a;
    lvl_n = act ? ((lvl_q & ~chg_vec_i) | hi_vec_i) : lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      lvl_q  <= '0;
      evt_q  <= '0;
      irq_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_val_i;
      lvl_q <= lvl_n;
      evt_q <= ev_b;
      irq_o <= latch_a | (act && (ev_b != '0));
      err_o <= any_chg && !mode;
    end
  end

  // R5: interrupt rises only with events pending
  a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (evt_q != '0));
  // R5: latch holds until a global clear
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !gclr) |=> irq_o);
  // R6: global clear without a new change empties everything
  a_r6_global_clear: assert property (@(posedge clk) disable iff (rst)
    (gclr && !any_chg) |=> (evt_q == '0 && !irq_o));
  // R3: events never hold a bit outside the mask after an update
  a_r3_events_masked: assert property (@(posedge clk) disable iff (rst)
    (act && !clr_wr_i) |=> ((evt_q & ~$past(mask_q)) == '0));
  // R9: disabled change flags an error and leaves levels alone
  a_r9_disabled_change: assert property (@(posedge clk) disable iff (rst)
    (any_chg && !mode) |=> (err_o && $stable(lvl_q)));
  // R7: partial clear never touches the latch
  a_r7_partial_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && !gclr && !act) |=> (irq_o == $past(irq_o)));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 8,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {5'd19, 5'd12, 5'd18}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_chg_i,
  input  logic [NUM_SRC-1:0] src_lvl_i,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               cpu_irq_o,
  output logic               mode_err_o
);
  logic [REG_W-1:0] chg_vec, hi_vec, mask_q, lvl_q, evt_q, mask_val, clr_val;
  logic             mask_wr, clr_wr;

  irqc_src_map #(.NUM_SRC(NUM_SRC), .SRC_POS(SRC_POS)) u_map (
    .chg_i(src_chg_i), .lvl_i(src_lvl_i),
    .chg_vec_o(chg_vec), .hi_vec_o(hi_vec)
  );

  irqc_regport #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mask_i(mask_q), .lvl_i(lvl_q), .evt_i(evt_q),
    .mask_wr_o(mask_wr), .mask_val_o(mask_val),
    .clr_wr_o(clr_wr), .clr_val_o(clr_val), .rdata_o(reg_rdata_o)
  );

  irqc_core u_core (
    .clk(clk), .rst(rst), .chg_vec_i(chg_vec), .hi_vec_i(hi_vec),
    .mask_wr_i(mask_wr), .mask_val_i(mask_val),
    .clr_wr_i(clr_wr), .clr_val_i(clr_val),
    .mask_q(mask_q), .lvl_q(lvl_q), .evt_q(evt_q),
    .irq_o(cpu_irq_o), .err_o(mode_err_o)
  );
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_chg = '0;
  logic [2:0]  src_lvl = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq, mode_err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_EVT = 8'h20, A_MSK = 8'h24, A_CLR = 8'h28, A_LVL = 8'h2C;

  always #2 clk = ~clk;

  irq_latch_ctrl i_irq_latch_ctrl (
    .clk(clk), .rst(rst), .src_chg_i(src_chg), .src_lvl_i(src_lvl),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cpu_irq_o(cpu_irq), .mode_err_o(mode_err)
  );

  function automatic logic [31:0] bs(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] value);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = bs(value);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] value);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    value = bs(reg_rdata);
  endtask

  task automatic pulse(input logic [2:0] chg, input logic [2:0] lvl);
    @(negedge clk);
    src_chg = chg; src_lvl = lvl;
    @(negedge clk);
    src_chg = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, cpu_irq}, 0);
    chk("R1 err", {31'b0, mode_err}, 0);
    chk("R1 rdata", reg_rdata, 0);
    rd(A_EVT, v); chk("R1 events", v, 0);
    rd(A_MSK, v); chk("R1 mask", v, 0);
    rd(A_LVL, v); chk("R1 levels", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    pulse(3'b001, 3'b001);
    chk("R9 err pulse", {31'b0, mode_err}, 1);
    @(negedge clk);
    chk("R9 err one cycle", {31'b0, mode_err}, 0);
    chk("R9 irq", {31'b0, cpu_irq}, 0);
    rd(A_EVT, v); chk("R9 events", v, 0);
    rd(A_LVL, v); chk("R9 levels", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_MSK, 32'h800C_1000);
    rd(A_MSK, v); chk("R8 mask readback", v, 32'h800C_1000);
    chk("R8 raw byte order", reg_rdata, 32'h0010_0C80);
    rd(A_CLR, v); chk("R8 clear reads 0", v, 0);
    rd(8'h30, v); chk("R8 unmapped reads 0", v, 0);
  endtask

  task automatic t_scsi_event();
    logic [31:0] v;
    pulse(3'b010, 3'b010);
    chk("R5 irq set", {31'b0, cpu_irq}, 1);
    rd(A_EVT, v); chk("R2 R3 events bit12", v, 32'h0000_1000);
    rd(A_LVL, v); chk("R4 levels bit12 high", v, 32'h0000_1000);
    pulse(3'b010, 3'b000);
    rd(A_LVL, v); chk("R4 levels bit12 low", v, 0);
    rd(A_EVT, v); chk("R3 events kept", v, 32'h0000_1000);
  endtask

  task automatic t_partial_clear();
    logic [31:0] v;
    wr(A_CLR, 32'h7FFF_EFFF);
    rd(A_EVT, v); chk("R7 events cleared", v, 0);
    chk("R7 irq unchanged", {31'b0, cpu_irq}, 1);
    chk("R5 irq held with no events", {31'b0, cpu_irq}, 1);
  endtask

  task automatic t_global_clear();
    logic [31:0] v;
    wr(A_CLR, 32'h8000_0000);
    chk("R6 irq dropped", {31'b0, cpu_irq}, 0);
    rd(A_EVT, v); chk("R6 events zero", v, 0);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(A_MSK, 32'h8000_1000);
    pulse(3'b001, 3'b001);
    chk("R3 masked no irq", {31'b0, cpu_irq}, 0);
    rd(A_EVT, v); chk("R3 masked no event", v, 0);
    rd(A_LVL, v); chk("R4 level despite mask", v, 32'h0004_0000);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    wr(A_MSK, 32'h800C_1000);
    pulse(3'b111, 3'b101);
    chk("R11 irq", {31'b0, cpu_irq}, 1);
    rd(A_EVT, v); chk("R11 events", v, 32'h000C_1000);
    rd(A_LVL, v); chk("R11 levels", v, 32'h000C_0000);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = bs(32'h8000_0000);
    src_chg = 3'b010; src_lvl = 3'b010;
    @(negedge clk);
    reg_wr = 1'b0; src_chg = '0;
    chk("R10 irq re-set", {31'b0, cpu_irq}, 1);
    rd(A_EVT, v); chk("R10 events only new", v, 32'h0000_1000);
    rd(A_LVL, v); chk("R10 levels", v, 32'h000C_1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_regs();
    t_scsi_event();
    t_partial_clear();
    t_global_clear();
    t_masked();
    t_multi();
    t_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule